// File: doc/BRIEF.md
# Iterative Multiply/Divide Step Unit

This block is a datapath slice that advances an unsigned multiply or divide by one bit for every step command it receives. It holds a pair of chained shift registers: an upper word that holds the accumulator or partial remainder, and a lower word that holds the multiplier or quotient. It also holds an operand register and an adder/subtractor. A step first decides whether the adder result is written into the upper word, and it shifts the two words as one double-width register in the same operation. Sixteen back-to-back steps after setup give a full 16-bit product or quotient and remainder. Driving the register pair through repeated steps under outside control gives multi-word arithmetic, with a carry input that chains the words together.

Software-style sequencing stays outside the block. A controller loads the three registers, then issues step strobes with a mode bit. The block takes one step every two clock cycles. `busy` acts as the inverse of a ready signal: a strobe seen while `busy` is high is dropped and is not held back for later. The same back-pressure rule applies to the load enables, which take effect only while `busy` is low. A strobe and a load in the same idle cycle are both taken, and the step then works on the freshly loaded values.

Top module: `mdstep_unit`

## Requirements
- R1: While `rst_n` is low, the upper word, the lower word and the operand register are all zero and `busy` is low.
- R2: With `busy` low, a high `ld_hi_en`, `ld_lo_en` or `ld_opd_en` writes `ld_data` into the upper word, the lower word or the operand register at the next rising edge, and `hi_out`, `lo_out` and `opd_out` show the result.
- R3: With `busy` low, a high `step_req` is accepted at the rising edge and `busy` is high for exactly the following cycle. The stepped values appear on `hi_out` and `lo_out` after the second rising edge, when `busy` falls again.
- R4: While `busy` is high, `step_req` and all three load enables are ignored: they start no extra step and change no register.
- R5: A multiply step (`step_mode` = 0) tests bit 0 of the lower word. If the bit is 1, it forms the 17-bit sum hi + opd + `chain_in`. The sum's carry goes to bit 15 of the upper word, the sum bits move right into the upper word, and sum bit 0 goes to bit 15 of the lower word. If the bit is 0, the pair shifts right by one with a 0 entering bit 15 of the upper word.
- R6: Starting from hi = 0, lo = a and opd = b, sixteen multiply steps with `chain_in` = 0 leave {hi, lo} equal to the 32-bit product a*b.
- R7: In a multiply step whose condition bit is 1, `chain_in` = 1 adds one to the sum. For example, hi = 0xFFFF, opd = 0 and lo = 0x0001 give hi = 0x8000 and lo = 0x0000.
- R8: A divide step (`step_mode` = 1) shifts the pair left by one, taking lo bit 15 into a 17-bit partial remainder. If that remainder is at least opd, remainder minus opd goes into the upper word and a 1 goes into lo bit 0. Otherwise the shifted remainder is kept and a 0 goes into lo bit 0. Starting from hi = 0, lo = a and opd = b (b nonzero), sixteen steps leave lo = a / b and hi = a mod b.
- R9: With opd = 0, every divide step enters a 1 into the quotient, so sixteen steps from hi = 0 and lo = a leave lo = 0xFFFF and hi = a.
- R10: `chain_in` has no effect on a divide step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_data | input | 16 | Data for register loads |
| ld_hi_en | input | 1 | Load the upper word |
| ld_lo_en | input | 1 | Load the lower word |
| ld_opd_en | input | 1 | Load the operand register |
| step_req | input | 1 | Step strobe |
| step_mode | input | 1 | 0 = multiply step, 1 = divide step |
| chain_in | input | 1 | Carry input used by multiply steps |
| busy | output | 1 | A step is in progress; strobes and loads are ignored |
| hi_out | output | 16 | Upper word readback |
| lo_out | output | 16 | Lower word readback |
| opd_out | output | 16 | Operand register readback |

## Verification
The hardest case to reach from the ports is a strobe or a load that arrives in the one busy cycle of a step. Random traffic seldom lands exactly there. The stimulus therefore holds `step_req` high for two consecutive cycles and pulses `ld_opd_en` only in the busy cycle. The scoreboard then has to see exactly one result, and the operand readback must stay unchanged. Full 16-step sequences check the product, quotient and remainder against plain arithmetic. This includes the all-ones multiply, a zero divisor and a divisor larger than the dividend.

// File: rtl/mdstep_pkg.sv
package mdstep_pkg;
  typedef enum logic {
    MODE_MUL = 1'b0,
    MODE_DIV = 1'b1
  } step_mode_e;
endpackage

// File: rtl/mdstep_seq.sv
// Two-cycle step sequencer: accept edge, then execute edge.
module mdstep_seq
  import mdstep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_req,
  input  logic       step_mode,
  input  logic       chain_in,
  output logic       busy,
  output logic       exec,
  output step_mode_e mode_q,
  output logic       chain_q
);
  logic accept;
  assign accept = step_req && !busy;
  assign exec   = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      mode_q  <= MODE_MUL;
      chain_q <= 1'b0;
    end else if (accept) begin
      busy    <= 1'b1;
      mode_q  <= step_mode_e'(step_mode);
      chain_q <= chain_in;
    end else begin
      busy    <= 1'b0;
    end
  end
endmodule

// File: rtl/mdstep_core.sv
// Combinational next-state of the chained register pair for one step.
module mdstep_core
  import mdstep_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] opd,
  input  step_mode_e   mode,
  input  logic         cin,
  output logic [W-1:0] hi_nx,
  output logic [W-1:0] lo_nx
);
  localparam int WX = W + 1;

  logic [WX-1:0] sum;
  logic [WX-1:0] rem;
  logic [WX-1:0] diff;
  logic          ge;

  assign sum  = {1'b0, hi} + {1'b0, opd} + {{W{1'b0}}, cin};
  assign rem  = {hi, lo[W-1]};
  assign diff = rem - {1'b0, opd};
  assign ge   = (rem >= {1'b0, opd});

  always_comb begin
    if (mode == MODE_MUL) begin
      if (lo[0]) begin
        hi_nx = sum[WX-1:1];
        lo_nx = {sum[0], lo[W-1:1]};
      end else begin
        hi_nx = {1'b0, hi[W-1:1]};
        lo_nx = {hi[0], lo[W-1:1]};
      end
    end else begin
      hi_nx = ge ? diff[W-1:0] : rem[W-1:0];
      lo_nx = {lo[W-2:0], ge};
    end
  end
endmodule

// File: rtl/mdstep_regs.sv
// Register pair plus operand, with idle-only loads and step update.
module mdstep_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         busy,
  input  logic         exec,
  input  logic [W-1:0] ld_data,
  input  logic         ld_hi_en,
  input  logic         ld_lo_en,
  input  logic         ld_opd_en,
  input  logic [W-1:0] hi_nx,
  input  logic [W-1:0] lo_nx,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo,
  output logic [W-1:0] opd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi  <= '0;
      lo  <= '0;
      opd <= '0;
    end else if (exec) begin
      hi <= hi_nx;
      lo <= lo_nx;
    end else if (!busy) begin
      if (ld_hi_en)  hi  <= ld_data;
      if (ld_lo_en)  lo  <= ld_data;
      if (ld_opd_en) opd <= ld_data;
    end
  end
endmodule

// File: rtl/mdstep_unit.sv
module mdstep_unit
  import mdstep_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ld_data,
  input  logic         ld_hi_en,
  input  logic         ld_lo_en,
  input  logic         ld_opd_en,
  input  logic         step_req,
  input  logic         step_mode,
  input  logic         chain_in,
  output logic         busy,
  output logic [W-1:0] hi_out,
  output logic [W-1:0] lo_out,
  output logic [W-1:0] opd_out
);
  logic         exec;
  step_mode_e   mode_q;
  logic         chain_q;
  logic [W-1:0] hi_nx;
  logic [W-1:0] lo_nx;

  mdstep_seq u_seq (
    .clk(clk), .rst_n(rst_n), .step_req(step_req), .step_mode(step_mode),
    .chain_in(chain_in), .busy(busy), .exec(exec), .mode_q(mode_q),
    .chain_q(chain_q)
  );

  mdstep_core #(.W(W)) u_core (
    .hi(hi_out), .lo(lo_out), .opd(opd_out), .mode(mode_q), .cin(chain_q),
    .hi_nx(hi_nx), .lo_nx(lo_nx)
  );

  mdstep_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .busy(busy), .exec(exec), .ld_data(ld_data),
    .ld_hi_en(ld_hi_en), .ld_lo_en(ld_lo_en), .ld_opd_en(ld_opd_en),
    .hi_nx(hi_nx), .lo_nx(lo_nx), .hi(hi_out), .lo(lo_out), .opd(opd_out)
  );
endmodule

// File: rtl/mdstep_chk.sv
module mdstep_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         step_req,
  input logic         ld_hi_en,
  input logic         ld_opd_en,
  input logic         busy,
  input logic [W-1:0] hi_out,
  input logic [W-1:0] lo_out,
  input logic [W-1:0] opd_out
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (hi_out == '0 && lo_out == '0 && opd_out == '0 && !busy)
        else $error("R1 registers not cleared in reset");
    end
  end

  p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && !busy) |=> busy);

  p_busy_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  p_opd_hold_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(opd_out));

  p_hi_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !step_req && !ld_hi_en) |=> $stable(hi_out));

  p_opd_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_opd_en) |=> $stable(opd_out));
endmodule

bind mdstep_unit mdstep_chk #(.W(W)) u_chk (.*);

// File: tb/sim_mdstep_unit.sv
module sim_mdstep_unit;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] ld_data = '0;
  logic         ld_hi_en = 1'b0, ld_lo_en = 1'b0, ld_opd_en = 1'b0;
  logic         step_req = 1'b0, step_mode = 1'b0, chain_in = 1'b0;
  logic         busy;
  logic [W-1:0] hi_out, lo_out, opd_out;

  always #5 clk = ~clk;

  mdstep_unit #(.W(W)) u0 (.*);

  typedef struct {
    logic [W-1:0] hi;
    logic [W-1:0] lo;
    string        tag;
  } exp_t;

  exp_t         sb[$];
  int           n_cmp = 0;
  int           n_bad = 0;
  logic [W-1:0] m_hi = '0, m_lo = '0, m_opd = '0;
  logic         prev_busy = 1'b0;
  bit           done = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bench model of one step, taken from R5 and R8.
  task automatic model_step(logic md, logic cin);
    logic [W:0] s, r;
    if (!md) begin
      if (m_lo[0]) begin
        s = {1'b0, m_hi} + {1'b0, m_opd} + {{W{1'b0}}, cin};
        m_lo = {s[0], m_lo[W-1:1]};
        m_hi = s[W:1];
      end else begin
        m_lo = {m_hi[0], m_lo[W-1:1]};
        m_hi = {1'b0, m_hi[W-1:1]};
      end
    end else begin
      r = {m_hi, m_lo[W-1]};
      if (r >= {1'b0, m_opd}) begin
        r = r - {1'b0, m_opd};
        m_lo = {m_lo[W-2:0], 1'b1};
      end else begin
        m_lo = {m_lo[W-2:0], 1'b0};
      end
      m_hi = r[W-1:0];
    end
  endtask

  // Monitor: a result is due on each falling edge of busy.
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_busy && !busy) begin
        if (sb.size() == 0) begin
          check("R4 unexpected step result", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.tag, {hi_out, lo_out}, {e.hi, e.lo});
        end
      end
      prev_busy = busy;
    end
  end

  task automatic load(logic [2:0] which, logic [W-1:0] d);
    @(negedge clk);
    ld_data = d; ld_hi_en = which[2]; ld_lo_en = which[1]; ld_opd_en = which[0];
    @(negedge clk);
    ld_hi_en = 0; ld_lo_en = 0; ld_opd_en = 0;
    if (which[2]) m_hi = d;
    if (which[1]) m_lo = d;
    if (which[0]) m_opd = d;
  endtask

  task automatic step(logic md, logic cin, string tag);
    exp_t e;
    @(negedge clk);
    step_req = 1; step_mode = md; chain_in = cin;
    model_step(md, cin);
    e.hi = m_hi; e.lo = m_lo; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    step_req = 0;
    @(negedge clk);
  endtask

  task automatic mul16(logic [W-1:0] a, logic [W-1:0] b);
    load(3'b111, 16'h0);
    load(3'b010, a);
    load(3'b001, b);
    for (int i = 0; i < 16; i++) step(1'b0, 1'b0, "R5 mul step");
    check("R6 product", {hi_out, lo_out}, a * b);
  endtask

  task automatic div16(logic [W-1:0] a, logic [W-1:0] b, logic cin);
    load(3'b111, 16'h0);
    load(3'b010, a);
    load(3'b001, b);
    for (int i = 0; i < 16; i++) step(1'b1, cin, "R8 div step");
    if (b != 0) begin
      check(cin ? "R10 quotient with chain_in=1" : "R8 quotient", {16'h0, lo_out}, {16'h0, a / b});
      check(cin ? "R10 remainder with chain_in=1" : "R8 remainder", {16'h0, hi_out}, {16'h0, a % b});
    end else begin
      check("R9 zero divisor quotient", {16'h0, lo_out}, 32'h0000FFFF);
      check("R9 zero divisor upper word", {16'h0, hi_out}, {16'h0, a});
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", {hi_out, lo_out}, 32'h0);
    check("R1 reset opd/busy", {15'h0, busy, opd_out}, 32'h0);
    rst_n = 1;

    load(3'b100, 16'hA5C3);
    check("R2 load hi", {16'h0, hi_out}, 32'h0000A5C3);
    load(3'b010, 16'h1F0E);
    load(3'b001, 16'h7777);
    check("R2 load lo/opd", {lo_out, opd_out}, 32'h1F0E7777);

    // R3 busy timing
    @(negedge clk);
    step_req = 1; step_mode = 0; chain_in = 0;
    model_step(1'b0, 1'b0);
    sb.push_back('{m_hi, m_lo, "R3 step result"});
    @(negedge clk);
    step_req = 0;
    check("R3 busy after accept", {31'h0, busy}, 32'd1);
    @(negedge clk);
    check("R3 busy drops", {31'h0, busy}, 32'd0);

    mul16(16'h1234, 16'h5678);
    mul16(16'hFFFF, 16'hFFFF);
    mul16(16'h0000, 16'hABCD);
    mul16(16'h8001, 16'h0003);

    // R7 chain_in carry
    load(3'b100, 16'hFFFF);
    load(3'b010, 16'h0001);
    load(3'b001, 16'h0000);
    step(1'b0, 1'b1, "R7 chain carry step");
    check("R7 chain carry value", {hi_out, lo_out}, 32'h80000000);

    div16(16'd1000, 16'd7, 1'b0);
    div16(16'hFFFF, 16'h0001, 1'b0);
    div16(16'h1234, 16'hFFFF, 1'b0);
    div16(16'hBEEF, 16'h0123, 1'b1);
    div16(16'h4C2D, 16'h0000, 1'b0);

    // R4 strobe held through busy cycle: exactly one step
    load(3'b111, 16'h0);
    load(3'b010, 16'h00F1);
    load(3'b001, 16'h0011);
    @(negedge clk);
    step_req = 1; step_mode = 0; chain_in = 0;
    model_step(1'b0, 1'b0);
    sb.push_back('{m_hi, m_lo, "R4 single accepted step"});
    @(negedge clk);
    ld_data = 16'hFFFF; ld_opd_en = 1; ld_hi_en = 1;
    @(negedge clk);
    step_req = 0; ld_opd_en = 0; ld_hi_en = 0;
    repeat (4) @(negedge clk);
    check("R4 ignored load opd", {16'h0, opd_out}, {16'h0, m_opd});
    check("R4 no pending result", sb.size(), 32'd0);
    check("R4 state after ignored strobe", {hi_out, lo_out}, {m_hi, m_lo});

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule